// File: doc/BRIEF.md
# Planar Read Path with Color Compare

This block sits between a four-plane display memory and the processor data bus. On every processor read strobe it captures the four plane bytes into a 32-bit latch word. It then returns one byte to the processor in the cycle after the strobe. The latch word is also driven out unchanged, so that a separate write path can use the captured data for its logical operations.

Two return formats are available. In plane mode the returned byte is the byte of one plane, picked by a two-bit plane selector. In match mode each returned bit reports whether the four-bit pixel at that bit position equals a programmed four-bit color. A per-plane participation mask removes chosen planes from that equality test. Memory storage and address decoding belong to neighbouring blocks.

Top module: `planar_read_path`

## Requirements
- R1: While rstN is low, and right after it rises, latchWord is 0, rdData is 0 and rdValid is 0.
- R2: A cycle with rdStrobe high loads planeBytes into latchWord, with plane p in bits [8p+7:8p]. The new value is visible from the following cycle, in both return modes.
- R3: With matchEn low, the rdData that follows a read equals the byte of the plane given by planeSel (0 to 3), taken from planeBytes in the strobe cycle.
- R4: With matchEn high, rdData bit i is 1 exactly when, for every plane p with careMask[p] = 1, bit i of plane p's byte equals matchColor[p].
- R5: With matchEn high, the value of planeSel has no effect on rdData.
- R6: With matchEn high and careMask = 4'b0000, rdData is 8'hFF whatever the plane bytes and matchColor are.
- R7: rdValid is high for exactly the one cycle after each strobe cycle, and low otherwise.
- R8: In cycles without rdStrobe, rdData and latchWord keep their values, even when planeBytes, planeSel, matchEn, matchColor or careMask change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdStrobe | input | 1 | Processor read: capture the planes and form the return byte |
| planeBytes | input | 32 | Four plane bytes from memory, plane p in bits [8p+7:8p] |
| planeSel | input | 2 | Plane returned in plane mode |
| matchEn | input | 1 | 1 selects match mode, 0 selects plane mode |
| matchColor | input | 4 | Compare color, one bit per plane |
| careMask | input | 4 | 1 where the plane takes part in the match |
| rdData | output | 8 | Byte returned to the processor |
| rdValid | output | 1 | rdData was updated in this cycle |
| latchWord | output | 32 | Captured plane bytes for the write path |

## Verification
The assertions assume that planeBytes and the mode and color inputs are settled in any cycle where rdStrobe is high. They also assume that rdStrobe stays low while reset is held. The bench meets both assumptions by driving every input on the falling clock edge and releasing each strobe after one cycle. It changes configuration only between reads, and keeps the strobe at zero throughout reset. Outputs are sampled on the falling edge after the capturing rising edge.

// File: rtl/planar_read_pkg.sv
package planar_read_pkg;
  localparam int NUM_PLANES = 4;
  localparam int PLANE_BITS = 8;
  localparam int SEL_BITS   = $clog2(NUM_PLANES);

  typedef struct packed {
    logic                loadLatches;
    logic                returnMatch;
    logic [SEL_BITS-1:0] planeIdx;
  } readStrobes_t;
endpackage

// File: rtl/planar_read_ctrl.sv
module planar_read_ctrl
  import planar_read_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdStrobe,
  input  logic                matchEn,
  input  logic [SEL_BITS-1:0] planeSel,
  output readStrobes_t        strobes,
  output logic                rdValid
);
  // Read request decode: every read loads the latches, mode decides the return path
  always_comb begin
    strobes.loadLatches = rdStrobe;
    strobes.returnMatch = matchEn;
    strobes.planeIdx    = matchEn ? '0 : planeSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdStrobe;
  end
endmodule

// File: rtl/planar_read_datapath.sv
module planar_read_datapath
  import planar_read_pkg::*;
#(
  parameter int PLANES = NUM_PLANES,
  parameter int BITS   = PLANE_BITS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  readStrobes_t           strobes,
  input  logic [PLANES*BITS-1:0] planeBytes,
  input  logic [PLANES-1:0]      matchColor,
  input  logic [PLANES-1:0]      careMask,
  output logic [BITS-1:0]        rdData,
  output logic [PLANES*BITS-1:0] latchWord
);
  localparam int WORD_W = PLANES * BITS;

  logic [BITS-1:0] planeMatch [PLANES];
  logic [BITS-1:0] matchVec;
  logic [BITS-1:0] planeByte;
  logic [BITS-1:0] nextData;

  // Per-plane capture and per-plane equality terms
  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    latchWord[p*BITS +: BITS] <= '0;
      else if (strobes.loadLatches) latchWord[p*BITS +: BITS] <= planeBytes[p*BITS +: BITS];
    end
    assign planeMatch[p] = ~(planeBytes[p*BITS +: BITS] ^ {BITS{matchColor[p]}})
                           | {BITS{~careMask[p]}};
  end

  always_comb begin
    matchVec = '1;
    for (int p = 0; p < PLANES; p++) matchVec &= planeMatch[p];
  end

  assign planeByte = planeBytes[int'(strobes.planeIdx)*BITS +: BITS];
  assign nextData  = strobes.returnMatch ? matchVec : planeByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    rdData <= '0;
    else if (strobes.loadLatches) rdData <= nextData;
  end

  logic unusedWidth;
  assign unusedWidth = ^WORD_W;
endmodule

// File: rtl/planar_read_path.sv
module planar_read_path
  import planar_read_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdStrobe,
  input  logic [31:0] planeBytes,
  input  logic [1:0]  planeSel,
  input  logic        matchEn,
  input  logic [3:0]  matchColor,
  input  logic [3:0]  careMask,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic [31:0] latchWord
);
  readStrobes_t strobes;

  planar_read_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .matchEn(matchEn),
    .planeSel(planeSel), .strobes(strobes), .rdValid(rdValid)
  );

  planar_read_datapath #(.PLANES(NUM_PLANES), .BITS(PLANE_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .planeBytes(planeBytes),
    .matchColor(matchColor), .careMask(careMask), .rdData(rdData),
    .latchWord(latchWord)
  );
endmodule

// File: rtl/planar_read_checker.sv
module planar_read_checker (
  input logic        clk,
  input logic        rstN,
  input logic        rdStrobe,
  input logic [31:0] planeBytes,
  input logic [1:0]  planeSel,
  input logic        matchEn,
  input logic [3:0]  careMask,
  input logic [7:0]  rdData,
  input logic        rdValid,
  input logic [31:0] latchWord
);
  logic [7:0] selByte;
  assign selByte = planeBytes[int'(planeSel)*8 +: 8];

  always_comb begin
    if (!rstN) assert_reset_clear_R1: assert (rdValid == 1'b0);
  end

  assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> latchWord == $past(planeBytes));

  assert_plane_return_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !matchEn) |=> rdData == $past(selByte));

  assert_all_masked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && matchEn && careMask == 4'b0000) |=> rdData == 8'hFF);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> rdValid);

  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> !rdValid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> ($stable(rdData) && $stable(latchWord)));
endmodule

bind planar_read_path planar_read_checker chk_i (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .planeBytes(planeBytes),
  .planeSel(planeSel), .matchEn(matchEn), .careMask(careMask),
  .rdData(rdData), .rdValid(rdValid), .latchWord(latchWord)
);

// File: tb/planar_read_path_tb.sv
module planar_read_path_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [31:0] planeBytes = '0;
  logic [1:0]  planeSel = '0;
  logic        matchEn = 1'b0;
  logic [3:0]  matchColor = '0;
  logic [3:0]  careMask = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic [31:0] latchWord;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  planar_read_path dut_i (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .planeBytes(planeBytes),
    .planeSel(planeSel), .matchEn(matchEn), .matchColor(matchColor),
    .careMask(careMask), .rdData(rdData), .rdValid(rdValid), .latchWord(latchWord)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected match vector, from the requirement text
  function automatic logic [7:0] expMatch(logic [31:0] d, logic [3:0] col, logic [3:0] care);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      r[i] = 1'b1;
      for (int p = 0; p < 4; p++)
        if (care[p] && (d[p*8+i] != col[p])) r[i] = 1'b0;
    end
    return r;
  endfunction

  // One read: drive at falling edge, strobe one cycle, sample at the next falling edge
  task automatic doRead(logic [31:0] d, logic [1:0] sel, logic en, logic [3:0] col, logic [3:0] care);
    @(negedge clk);
    planeBytes = d; planeSel = sel; matchEn = en; matchColor = col; careMask = care;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic testReset();
    check("R1 rdData", {24'd0, rdData}, 32'd0);
    check("R1 rdValid", {31'd0, rdValid}, 32'd0);
    check("R1 latchWord", latchWord, 32'd0);
  endtask

  task automatic testPlaneMode();
    logic [31:0] d = 32'hA5_3C_F0_17;
    for (int s = 0; s < 4; s++) begin
      doRead(d, 2'(s), 1'b0, 4'h0, 4'hF);
      check("R3 plane byte", {24'd0, rdData}, {24'd0, d[s*8 +: 8]});
      check("R2 latch load", latchWord, d);
      check("R7 valid high", {31'd0, rdValid}, 32'd1);
    end
  endtask

  task automatic testMatchMode();
    logic [31:0] pats [4] = '{32'hFF_00_FF_00, 32'h12_34_56_78, 32'h0F_F0_AA_55, 32'hC3_3C_99_66};
    logic [3:0]  cols [4] = '{4'b0101, 4'b1010, 4'b1111, 4'b0011};
    logic [3:0]  cares[4] = '{4'b1111, 4'b1011, 4'b0110, 4'b0001};
    for (int k = 0; k < 4; k++) begin
      doRead(pats[k], 2'd2, 1'b1, cols[k], cares[k]);
      check("R4 match vector", {24'd0, rdData}, {24'd0, expMatch(pats[k], cols[k], cares[k])});
      check("R2 latch in match mode", latchWord, pats[k]);
    end
  endtask

  task automatic testSelIgnored();
    logic [31:0] d = 32'h5A_69_E1_0F;
    for (int s = 0; s < 4; s++) begin
      doRead(d, 2'(s), 1'b1, 4'b1001, 4'b1101);
      check("R5 sel ignored", {24'd0, rdData}, {24'd0, expMatch(d, 4'b1001, 4'b1101)});
    end
  endtask

  task automatic testAllMasked();
    doRead(32'h00_00_00_00, 2'd1, 1'b1, 4'b1111, 4'b0000);
    check("R6 all masked", {24'd0, rdData}, 32'hFF);
    doRead(32'h13_57_9B_DF, 2'd3, 1'b1, 4'b0110, 4'b0000);
    check("R6 all masked", {24'd0, rdData}, 32'hFF);
  endtask

  task automatic testHold();
    logic [31:0] d = 32'hDE_AD_BE_EF;
    doRead(d, 2'd1, 1'b0, 4'h0, 4'hF);
    check("R3 plane 1", {24'd0, rdData}, 32'hBE);
    @(negedge clk);
    check("R7 valid low", {31'd0, rdValid}, 32'd0);
    planeBytes = 32'h11_22_33_44; planeSel = 2'd3; matchEn = 1'b1;
    matchColor = 4'hF; careMask = 4'h0;
    repeat (3) @(negedge clk);
    check("R8 rdData hold", {24'd0, rdData}, 32'hBE);
    check("R8 latch hold", latchWord, d);
    check("R7 valid stays low", {31'd0, rdValid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlaneMode();
    testMatchMode();
    testSelIgnored();
    testAllMasked();
    testHold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule